// File: doc/BRIEF.md
# Glitch-Free Power-Down Clock Stopper

This block sits between a set of free-running clock sources and the chip's clock pins. When an asynchronous active-low power-down request arrives, it stops every output cleanly and then tells the oscillator it may shut down. Single-ended outputs come to rest low. Each differential pair comes to rest with its true leg high. A per-pair mode bit chooses whether that pair's true leg keeps driving or both legs float. When the request is withdrawn, each output picks up its source again with no shortened pulse.

The sources are oversampled by a fast reference clock `clk`, and all decisions are registered on it. The request first goes through a two-flop synchronizer. It is then qualified by counting rising edges of the first pair's complement source. Once the request is qualified, every output watches its own source for a high-to-low transition. For a differential pair, that source is the complement leg. At that transition the output's park flag takes the qualified value, so parking and release both happen on a falling edge of the output's own source. The oscillator-off flag follows one cycle after every output is parked and the request is still qualified.

Top module: `clk_park_ctrl`

## Requirements
- R1: No output is gated until the synchronized request has been seen low at two rising edges of `dp_src_c[0]`. Until then every output equals its source and every output enable is 1.
- R2: Once the request is qualified, each single-ended output is forced low from the first falling edge of its own source. Before that edge it follows the source.
- R3: Once the request is qualified, each pair is parked from the first falling edge of its complement source. While parked, `dp_out_t` is 1 and `dp_out_c` is 0.
- R4: An unparked pair has both enables at 1. A parked pair with `dp_float` bit 0 has the true enable at 1 and the complement enable at 0. A parked pair with `dp_float` bit 1 has both enables at 0.
- R5: `parked_all` is 1 exactly when every single-ended output and every pair is parked.
- R6: `osc_off` is 1 only while `parked_all` is 1. It rises one cycle after all outputs are parked while the request is still qualified, and it falls one cycle after the qualification clears.
- R7: After the request is released, each output resumes at a falling edge of its own source (the complement leg for pairs). Every high pulse on a single-ended output or on `dp_out_c` is exactly as long as the source's high phase.
- R8: A request held low for at most two `clk` cycles parks nothing.
- R9: While `rst_n` is low, all outputs follow their sources, all enables are 1, and `parked_all` and `osc_off` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that oversamples all sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| se_src | input | SE_W | Single-ended source clocks |
| dp_src_t | input | DP_W | True legs of the differential sources |
| dp_src_c | input | DP_W | Complement legs; bit 0 qualifies the request |
| dp_float | input | DP_W | Per-pair mode: 0 drives true high when parked, 1 floats both legs |
| se_out | output | SE_W | Gated single-ended clocks |
| dp_out_t | output | DP_W | Gated true legs |
| dp_out_c | output | DP_W | Gated complement legs |
| dp_oe_t | output | DP_W | Output enable of each true leg |
| dp_oe_c | output | DP_W | Output enable of each complement leg |
| parked_all | output | 1 | Every output has reached its parked state |
| osc_off | output | 1 | Oscillator may be shut off |

## Verification
The assertions assume that every source is a level that changes away from the `clk` edge and holds for at least one `clk` cycle per phase. They also assume each complement leg is the exact inverse of its true leg. The bench builds each source from a whole-number half period of one to four cycles, driven on the falling edge of `clk`, and always derives the complement by inversion. The request is changed only at those same instants; it reaches the logic only through the synchronizer.

// File: rtl/clk_park_ctrl.sv
`timescale 1ns/1ps
module clk_park_ctrl #(
  parameter int SE_W       = 4,
  parameter int DP_W       = 2,
  parameter int QUAL_EDGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_req_n,
  input  logic [SE_W-1:0] se_src,
  input  logic [DP_W-1:0] dp_src_t,
  input  logic [DP_W-1:0] dp_src_c,
  input  logic [DP_W-1:0] dp_float,
  output logic [SE_W-1:0] se_out,
  output logic [DP_W-1:0] dp_out_t,
  output logic [DP_W-1:0] dp_out_c,
  output logic [DP_W-1:0] dp_oe_t,
  output logic [DP_W-1:0] dp_oe_c,
  output logic            parked_all,
  output logic            osc_off
);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  logic [1:0]      pd_sync;
  logic            cc_q;
  logic [QW-1:0]   qcnt;
  logic [SE_W-1:0] se_q, se_park, se_fall;
  logic [DP_W-1:0] dc_q, dp_park, dc_fall;
  logic            stop, cc_rise;

  assign stop    = (qcnt == QW'(QUAL_EDGES));
  assign cc_rise = dp_src_c[0] & ~cc_q;
  assign se_fall = se_q & ~se_src;
  assign dc_fall = dc_q & ~dp_src_c;

  assign se_out     = se_src & ~se_park;
  assign dp_out_t   = dp_src_t | dp_park;
  assign dp_out_c   = dp_src_c & ~dp_park;
  assign dp_oe_t    = ~(dp_park & dp_float);
  assign dp_oe_c    = ~dp_park;
  assign parked_all = (&se_park) & (&dp_park);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sync <= 2'b11;
      cc_q    <= 1'b0;
      qcnt    <= '0;
      se_q    <= '0;
      dc_q    <= '0;
      se_park <= '0;
      dp_park <= '0;
      osc_off <= 1'b0;
    end else begin
      pd_sync <= {pd_sync[0], pd_req_n};
      cc_q    <= dp_src_c[0];
      se_q    <= se_src;
      dc_q    <= dp_src_c;
      if (pd_sync[1])
        qcnt <= '0;
      else if (cc_rise && !stop)
        qcnt <= qcnt + QW'(1);
      for (int i = 0; i < SE_W; i++)
        if (se_fall[i]) se_park[i] <= stop;
      for (int j = 0; j < DP_W; j++)
        if (dc_fall[j]) dp_park[j] <= stop;
      osc_off <= stop & parked_all;
    end
  end

  assert_qual_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> $past(cc_rise) && !$past(pd_sync[1]));

  assert_osc_needs_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> parked_all);

  assert_osc_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_off) |-> $past(parked_all) && $past(stop));

  for (genvar g = 0; g < SE_W; g++) begin : g_se_chk
    assert_se_park_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(se_park[g]) |-> $past(stop) && !$past(se_src[g]));
    assert_se_resume_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se_park[g]) |-> !$past(stop) && !$past(se_src[g]));
  end

  for (genvar g = 0; g < DP_W; g++) begin : g_dp_chk
    assert_dp_park_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dp_park[g]) |-> $past(stop) && !$past(dp_src_c[g]));
    assert_dp_resume_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dp_park[g]) |-> !$past(stop) && !$past(dp_src_c[g]));
  end
endmodule

// File: tb/tb_clk_park_ctrl.sv
`timescale 1ns/1ps
module tb_clk_park_ctrl;
  localparam int NS = 4;
  localparam int ND = 2;
  localparam int NG = NS + ND;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, pd_n;
  logic [NS-1:0] se_src;
  logic [ND-1:0] dp_t, dp_c, dp_float;
  logic [NS-1:0] se_out;
  logic [ND-1:0] dp_out_t, dp_out_c, dp_oe_t, dp_oe_c;
  logic          parked_all, osc_off;

  int   hp[NG];
  int   cnt[NG];
  logic lvl[NG];
  int   ws[NS];
  int   wc[ND];
  int   nvec = 0, nfail = 0;
  bit   done = 0;
  bit   last_gated;

  logic          m_s1, m_s2, m_cc, m_osc;
  int            m_q;
  logic [NS-1:0] m_sq, m_sp;
  logic [ND-1:0] m_dq, m_dp;

  clk_park_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_n),
    .se_src(se_src), .dp_src_t(dp_t), .dp_src_c(dp_c), .dp_float(dp_float),
    .se_out(se_out), .dp_out_t(dp_out_t), .dp_out_c(dp_out_c),
    .dp_oe_t(dp_oe_t), .dp_oe_c(dp_oe_c),
    .parked_all(parked_all), .osc_off(osc_off));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive_src();
    for (int g = 0; g < NG; g++) begin
      if (cnt[g] <= 1) begin lvl[g] = ~lvl[g]; cnt[g] = hp[g]; end
      else cnt[g]--;
    end
    for (int i = 0; i < NS; i++) se_src[i] = lvl[i];
    for (int j = 0; j < ND; j++) begin dp_t[j] = lvl[NS+j]; dp_c[j] = ~lvl[NS+j]; end
  endtask

  function automatic bit gated_now();
    return (se_out !== se_src) || (dp_out_t !== dp_t) || (dp_out_c !== dp_c) ||
           (dp_oe_t !== '1) || (dp_oe_c !== '1);
  endfunction

  task automatic track_width(input logic o, input int h, inout int w, input string what);
    if (o) begin
      if (w >= 0) w++;
    end else begin
      if (w > 0) chk(w == h, "R7", what, 32'(w), 32'(h));
      w = 0;
    end
  endtask

  task automatic check_outputs();
    logic [NS-1:0] e_se;
    logic [ND-1:0] e_dt, e_dc, e_toe, e_coe;
    e_se  = se_src & ~m_sp;
    e_dt  = dp_t | m_dp;
    e_dc  = dp_c & ~m_dp;
    e_toe = ~(m_dp & dp_float);
    e_coe = ~m_dp;
    chk(se_out === e_se, "R2", "se_out", 32'(se_out), 32'(e_se));
    chk(dp_out_t === e_dt, "R3", "dp_out_t", 32'(dp_out_t), 32'(e_dt));
    chk(dp_out_c === e_dc, "R3", "dp_out_c", 32'(dp_out_c), 32'(e_dc));
    chk({dp_oe_t, dp_oe_c} === {e_toe, e_coe}, "R4", "enables",
        32'({dp_oe_t, dp_oe_c}), 32'({e_toe, e_coe}));
    chk(parked_all === ((&m_sp) & (&m_dp)), "R5", "parked_all",
        32'(parked_all), 32'((&m_sp) & (&m_dp)));
    chk(osc_off === m_osc, "R6", "osc_off", 32'(osc_off), 32'(m_osc));
    last_gated = gated_now();
    if (m_q < 2 && m_sp == '0 && m_dp == '0)
      chk(!last_gated, "R1", "gating before qualification", 32'(last_gated), 32'(0));
    for (int i = 0; i < NS; i++) track_width(se_out[i], hp[i], ws[i], "se_out pulse width");
    for (int j = 0; j < ND; j++) track_width(dp_out_c[j], hp[NS+j], wc[j], "dp_out_c pulse width");
  endtask

  task automatic model_edge();
    bit stop, rise, allp;
    stop = (m_q == 2);
    rise = dp_c[0] & ~m_cc;
    allp = (&m_sp) & (&m_dp);
    for (int i = 0; i < NS; i++) if (m_sq[i] & ~se_src[i]) m_sp[i] = stop;
    for (int j = 0; j < ND; j++) if (m_dq[j] & ~dp_c[j]) m_dp[j] = stop;
    m_osc = stop & allp;
    if (m_s2) m_q = 0;
    else if (rise && m_q < 2) m_q = m_q + 1;
    m_cc = dp_c[0];
    m_sq = se_src;
    m_dq = dp_c;
    m_s2 = m_s1;
    m_s1 = pd_n;
  endtask

  task automatic cyc(input logic pdv);
    @(negedge clk);
    pd_n = pdv;
    drive_src();
    #1;
    check_outputs();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #750us;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'h5EED_C10C));
    for (int g = 0; g < NG; g++) begin
      hp[g]  = 1 + int'($urandom % 4);
      lvl[g] = 1'b0;
    end
    hp[0]    = 1;
    hp[NG-1] = 4;
    for (int g = 0; g < NG; g++) cnt[g] = 1 + int'($urandom % 32'(hp[g]));
    for (int i = 0; i < NS; i++) ws[i] = -1;
    for (int j = 0; j < ND; j++) wc[j] = -1;
    m_s1 = 1; m_s2 = 1; m_cc = 0; m_q = 0; m_osc = 0;
    m_sq = '0; m_sp = '0; m_dq = '0; m_dp = '0;
    rst_n = 0; pd_n = 1; dp_float = '0;
    se_src = '0; dp_t = '0; dp_c = '1;

    // R9: reset state, with the request also asserted to show it is held off
    repeat (6) begin
      @(negedge clk);
      pd_n = 1'b0;
      drive_src();
      #1;
      chk(se_out === se_src && dp_out_t === dp_t && dp_out_c === dp_c, "R9",
          "outputs follow sources in reset", 32'(se_out), 32'(se_src));
      chk(parked_all === 1'b0 && osc_off === 1'b0 && dp_oe_t === '1 && dp_oe_c === '1,
          "R9", "status and enables in reset", 32'({parked_all, osc_off, dp_oe_t, dp_oe_c}),
          32'({2'b00, {ND{1'b1}}, {ND{1'b1}}}));
    end
    pd_n  = 1'b1;
    rst_n = 1'b1;
    @(posedge clk);
    model_edge();

    for (int k = 0; k < 36; k++) begin
      dp_float = ND'($urandom);
      if (k == 1) dp_float = '1;
      if (k == 2) dp_float = '0;
      repeat (8 + int'($urandom % 30)) cyc(1'b1);
      if (k % 4 == 3) begin
        // R8: request glitch of one or two cycles
        seen = 0;
        repeat (1 + (k / 4) % 2) begin cyc(1'b0); seen |= last_gated; end
        repeat (12) begin cyc(1'b1); seen |= last_gated; end
        chk(!seen, "R8", "short request gated an output", 32'(seen), 32'(0));
      end else begin
        repeat (30 + int'($urandom % 50)) cyc(1'b0);
        repeat (20 + int'($urandom % 20)) cyc(1'b1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule